// File: doc/BRIEF.md
# Linearizing Baseline-Tracking Sample Conditioner

This block conditions one channel of 12-bit digitizer samples at the system clock. Each accepted sample is first passed through a programmable 4096-entry correction table, which maps raw codes to calibrated, linearized codes. A running baseline estimate is then subtracted from the corrected value. The result leaves the block as a 13-bit signed stream together with a valid flag.

The baseline is an exponential average with four fractional bits. It only follows the signal while the corrected sample sits strictly below a programmable threshold, so pulses riding on the baseline do not drag it upward. The first accepted sample after reset seeds the baseline directly.

The threshold and the averaging shift travel down the pipeline with their sample. A stream-enable input separates two phases: table loading while it is low, and sample processing while it is high.

Top module: `baseline_conditioner`

## Requirements
- R1: An input sample is accepted on a rising edge where `in_valid` and `run_en` are both high. Its result is presented with `out_valid` high after the fourth rising edge, counting the accepting edge as the first. `out_valid` is never high without such an accepted sample four edges earlier.
- R2: The corrected value of a sample is the table word stored at the address equal to the raw 12-bit sample.
- R3: `out_data` equals the corrected value minus the baseline integer part held before this sample. The baseline integer part is the baseline with its 4 fractional bits dropped (floor). The result is 13-bit two's complement, reaching down to -4095 without wrapping, and is never -4096.
- R4: The first accepted sample after reset loads the baseline with its corrected value (fraction zero) and produces an output of 0.
- R5: A later sample whose corrected value is equal to or above its threshold leaves the baseline unchanged.
- R6: A later sample whose corrected value C is strictly below its threshold updates the baseline B, which is kept in units of 1/16. The update is B := B + floor((16*C - B) / 2^k).
- R7: The shift k is taken from `shift_sel`. Codes below 2 act as 2, codes above 6 act as 6, and codes 2 to 6 are used as is.
- R8: A table write (`tbl_we` high on a rising edge) takes effect only while `run_en` is low. While `run_en` is high it is ignored, and the table keeps its previous word.
- R9: A sample presented with `in_valid` high while `run_en` is low is ignored. It produces no output and does not touch the baseline.
- R10: While reset is high and on the cycle after it, `out_valid` and `out_data` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Streaming enable; low allows table writes |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 12 | Raw sample code |
| thresh | input | 12 | Baseline update threshold, captured with the sample |
| shift_sel | input | 3 | Averaging shift code, captured with the sample |
| tbl_we | input | 1 | Correction table write strobe |
| tbl_addr | input | 12 | Correction table write address |
| tbl_data | input | 12 | Correction table write word |
| out_valid | output | 1 | Result strobe |
| out_data | output | 13 | Signed baseline-subtracted sample |

## Verification
The checker assumes the table is never written while samples are still inside the pipeline. The bench therefore loads the table only after several idle cycles with streaming disabled. The latency properties assume reset is not raised while a sample is in flight, so the bench drains the pipeline before each reset pulse. The threshold and shift inputs need no such care, because they are captured with each sample; the stimulus deliberately changes them from one sample to the next.

// File: rtl/bl_pkg.sv
package bl_pkg;

    localparam int SMP_W  = 12;
    localparam int FRAC_W = 4;
    localparam int KSEL_W = 3;
    localparam int K_MIN  = 2;
    localparam int K_MAX  = 6;
    localparam int BASE_W = SMP_W + FRAC_W;
    localparam int OUT_W  = SMP_W + 1;

    // control fields that ride along with a sample
    typedef struct packed {
        logic              vld;
        logic [SMP_W-1:0]  thr;
        logic [KSEL_W-1:0] ksel;
    } ctl_t;

    function automatic logic [KSEL_W-1:0] clamp_shift(input logic [KSEL_W-1:0] sel);
        if (sel < KSEL_W'(K_MIN)) return KSEL_W'(K_MIN);
        if (sel > KSEL_W'(K_MAX)) return KSEL_W'(K_MAX);
        return sel;
    endfunction

endpackage

// File: rtl/bl_cal_lut.sv
module bl_cal_lut #(
    parameter int AW = 12,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // registered read: one pipeline stage
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/bl_base_track.sv
module bl_base_track
    import bl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_vld,
    input  logic [SMP_W-1:0]  corr,
    input  logic [SMP_W-1:0]  thr,
    input  logic [KSEL_W-1:0] ksel,
    output logic [SMP_W-1:0]  ref_val,
    output logic [BASE_W-1:0] base_q,
    output logic              primed
);
    logic [KSEL_W-1:0]        k_eff;
    logic signed [BASE_W+1:0] delta;
    logic signed [BASE_W+1:0] step;

    assign k_eff = clamp_shift(ksel);

    always_comb begin
        delta = $signed({2'b00, corr, {FRAC_W{1'b0}}}) - $signed({2'b00, base_q});
        step  = delta >>> k_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            primed <= 1'b0;
        end else if (upd_vld) begin
            if (!primed) begin
                base_q <= {corr, {FRAC_W{1'b0}}};
                primed <= 1'b1;
            end else if (corr < thr) begin
                base_q <= base_q + step[BASE_W-1:0];
            end
        end
    end

    // value subtracted from the sample currently at this stage
    assign ref_val = primed ? base_q[BASE_W-1 -: SMP_W] : corr;
endmodule

// File: rtl/baseline_conditioner.sv
module baseline_conditioner
    import bl_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run_en,
    input  logic                    in_valid,
    input  logic [11:0]             in_sample,
    input  logic [11:0]             thresh,
    input  logic [2:0]              shift_sel,
    input  logic                    tbl_we,
    input  logic [11:0]             tbl_addr,
    input  logic [11:0]             tbl_data,
    output logic                    out_valid,
    output logic signed [12:0]      out_data
);
    ctl_t                     s1_ctl, s2_ctl;
    logic [SMP_W-1:0]         s1_smp;
    logic [SMP_W-1:0]         lut_q;
    logic [SMP_W-1:0]         ref_val;
    logic [BASE_W-1:0]        base_q;
    logic                     primed;
    logic                     s3_vld;
    logic signed [OUT_W-1:0]  s3_diff;

    // stage 1: capture sample and its controls
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_ctl <= '0;
        end else begin
            s1_ctl.vld  <= in_valid && run_en;
            s1_ctl.thr  <= thresh;
            s1_ctl.ksel <= shift_sel;
        end
        s1_smp <= in_sample;
    end

    // stage 2: table lookup, controls follow alongside
    bl_cal_lut #(.AW(SMP_W), .DW(SMP_W)) lut_i (
        .clk     (clk),
        .wr_en   (tbl_we && !run_en),
        .wr_addr (tbl_addr),
        .wr_data (tbl_data),
        .rd_addr (s1_smp),
        .rd_data (lut_q)
    );

    always_ff @(posedge clk) begin
        if (rst) s2_ctl <= '0;
        else     s2_ctl <= s1_ctl;
    end

    // stage 3: subtract stored baseline, update baseline
    bl_base_track trk_i (
        .clk     (clk),
        .rst     (rst),
        .upd_vld (s2_ctl.vld),
        .corr    (lut_q),
        .thr     (s2_ctl.thr),
        .ksel    (s2_ctl.ksel),
        .ref_val (ref_val),
        .base_q  (base_q),
        .primed  (primed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s3_vld  <= 1'b0;
            s3_diff <= '0;
        end else begin
            s3_vld  <= s2_ctl.vld;
            s3_diff <= $signed({1'b0, lut_q}) - $signed({1'b0, ref_val});
        end
    end

    // stage 4: output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s3_vld;
            if (s3_vld) out_data <= s3_diff;
        end
    end
endmodule

// File: rtl/bl_checker.sv
module bl_checker (
    input logic        clk,
    input logic        rst,
    input logic        run_en,
    input logic        in_valid,
    input logic        out_valid,
    input logic [12:0] out_data,
    input logic        s2_vld,
    input logic [11:0] corr,
    input logic [11:0] thr,
    input logic        primed,
    input logic [15:0] base_q
);
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && run_en) |-> ##4 out_valid);

    p_origin_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && run_en, 4));

    p_reset_idle_r10: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_data == 13'd0));

    p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data != {1'b1, 12'd0}));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (s2_vld && primed && corr >= thr) |=> $stable(base_q));

    p_seed_r4: assert property (@(posedge clk) disable iff (rst)
        (s2_vld && !primed) |=> (primed && base_q == {$past(corr), 4'd0}));
endmodule

bind baseline_conditioner bl_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .s2_vld    (s2_ctl.vld),
    .corr      (lut_q),
    .thr       (s2_ctl.thr),
    .primed    (primed),
    .base_q    (base_q)
);

// File: tb/baseline_conditioner_tb_top.sv
module baseline_conditioner_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_sample = '0;
    logic [11:0] thresh = '0;
    logic [2:0]  shift_sel = '0;
    logic        tbl_we = 1'b0;
    logic [11:0] tbl_addr = '0;
    logic [11:0] tbl_data = '0;
    logic        out_valid;
    logic signed [12:0] out_data;

    always #5 clk = ~clk;

    baseline_conditioner dut_i (
        .clk(clk), .rst(rst), .run_en(run_en), .in_valid(in_valid),
        .in_sample(in_sample), .thresh(thresh), .shift_sel(shift_sel),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bench-side model of table and baseline
    int    lut_m [4096];
    int    m_base = 0;
    bit    m_primed = 1'b0;
    int    exp_val [512];
    int    exp_cyc [512];
    string exp_tag [512];
    int    wr_ix = 0;
    int    rd_ix = 0;

    // stimulus table: {gap, sample, threshold, shift code}
    localparam int NVEC = 16;
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b0, 12'd200,  12'd1000, 3'd2},
        {1'b0, 12'd220,  12'd1000, 3'd2},
        {1'b0, 12'd180,  12'd1000, 3'd0},
        {1'b1, 12'd0,    12'd0,    3'd0},
        {1'b0, 12'd900,  12'd1000, 3'd4},
        {1'b0, 12'd240,  12'd1000, 3'd4},
        {1'b0, 12'd240,  12'd1000, 3'd7},
        {1'b0, 12'd260,  12'd1000, 3'd6},
        {1'b0, 12'd666,  12'd1000, 3'd3},
        {1'b0, 12'd667,  12'd1000, 3'd3},
        {1'b0, 12'd100,  12'd1000, 3'd5},
        {1'b1, 12'd0,    12'd0,    3'd0},
        {1'b1, 12'd0,    12'd0,    3'd0},
        {1'b0, 12'd150,  12'd1000, 3'd2},
        {1'b0, 12'd2729, 12'd1000, 3'd2},
        {1'b0, 12'd50,   12'd1000, 3'd1}
    };

    function automatic int tbl_fn(input int a);
        return (a < 2730) ? a + a / 2 : 4095;
    endfunction

    // expected output per R2..R7
    function automatic int model_step(input int smp, input int thr, input int k);
        int c, kk, res;
        c  = lut_m[smp];
        kk = (k < 2) ? 2 : ((k > 6) ? 6 : k);
        if (!m_primed) begin
            m_base = c * 16;
            m_primed = 1'b1;
            res = 0;
        end else begin
            res = c - (m_base >>> 4);
            if (c < thr) m_base = m_base + ((c * 16 - m_base) >>> kk);
        end
        return res;
    endfunction

    task automatic send(input int smp, input int thr, input int k, input string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = smp[11:0];
        thresh    = thr[11:0];
        shift_sel = k[2:0];
        exp_val[wr_ix] = model_step(smp, thr, k);
        exp_cyc[wr_ix] = cyc + 4;
        exp_tag[wr_ix] = tag;
        wr_ix++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            tbl_we   = 1'b0;
        end
    endtask

    task automatic tbl_write(input int a, input int d);
        @(negedge clk);
        in_valid = 1'b0;
        tbl_we   = 1'b1;
        tbl_addr = a[11:0];
        tbl_data = d[11:0];
        if (!run_en) lut_m[a] = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        m_primed = 1'b0;
        m_base = 0;
        repeat (2) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== 13'sd0) begin
            n_fail++;
            $display("FAIL R10 reset state: valid=%0b data=%0d expected 0/0", out_valid, out_data);
        end
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== 13'sd0) begin
            n_fail++;
            $display("FAIL R10 after reset: valid=%0b data=%0d expected 0/0", out_valid, out_data);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // output monitor: latency (R1) and values
    always @(negedge clk) begin
        if (!rst) begin
            bit due;
            due = (rd_ix < wr_ix) && (exp_cyc[rd_ix] == cyc);
            if (due || out_valid) begin
                n_chk++;
                if (out_valid !== due) begin
                    n_fail++;
                    $display("FAIL R1 out_valid=%0b expected %0b at cycle %0d", out_valid, due, cyc);
                end else if (int'(out_data) != exp_val[rd_ix]) begin
                    n_fail++;
                    $display("FAIL %s data=%0d expected %0d", exp_tag[rd_ix],
                             int'(out_data), exp_val[rd_ix]);
                end
                if (due) rd_ix++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        pulse_reset();

        // load table with streaming off (R8)
        run_en = 1'b0;
        for (int a = 0; a < 4096; a++) begin
            @(negedge clk);
            tbl_we   = 1'b1;
            tbl_addr = a[11:0];
            tbl_data = 12'(tbl_fn(a));
            lut_m[a] = tbl_fn(a);
        end
        tbl_write(4000, 0);
        idle(3);
        run_en = 1'b1;

        // R4 seed from first sample, R3 deepest negative excursion
        send(2730, 0, 2, "R4 seed");
        send(4000, 0, 2, "R3 no wrap");
        idle(8);

        // R9: sample while streaming disabled is dropped
        @(negedge clk);
        run_en = 1'b0;
        in_valid = 1'b1;
        in_sample = 12'd10;
        thresh = 12'd4095;
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            n_chk++;
            if (out_valid !== 1'b0) begin
                n_fail++;
                $display("FAIL R9 out_valid=%0b expected 0", out_valid);
            end
        end
        run_en = 1'b1;
        send(100, 4095, 2, "R9 baseline untouched");
        idle(8);

        pulse_reset();

        // stimulus table walk (R2 R5 R6 R7)
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][27]) idle(1);
            else send(int'(VEC[v][26:15]), int'(VEC[v][14:3]), int'(VEC[v][2:0]),
                      "R2 R5 R6 R7 table");
        end
        idle(8);

        // R8: write ignored while streaming
        tbl_write(200, 7);
        send(200, 0, 2, "R8 write ignored");
        idle(8);
        run_en = 1'b0;
        tbl_write(200, 7);
        idle(2);
        run_en = 1'b1;
        send(200, 0, 2, "R8 write accepted");
        idle(8);

        n_chk++;
        if (rd_ix != wr_ix) begin
            n_fail++;
            $display("FAIL R1 outputs seen=%0d expected %0d", rd_ix, wr_ix);
        end
        summary();
        $finish;
    end
endmodule